// File: doc/BRIEF.md
# Systolic Pipelined FIR Filter

This block is a single-rate, non-symmetric FIR filter of configurable order. It is built from `TAPS` identical tap stages. Each stage holds one coefficient, a multiplier with two register stages, and a registered two-input post-adder. The stages are linked by two chains. A delay chain carries each input sample forward with two registers per stage. A partial-sum chain carries each stage's registered sum into the adder of the next stage.

Every arithmetic operator has its own output register, so no combinational path grows with the filter order. The price is a fixed latency of `TAPS + 2` cycles. The output stream is exactly the direct-form convolution of the input stream, shifted by that latency.

Coefficients arrive on a static port and are expected to change only while reset is held. A sample is accepted in each cycle where `in_valid` is high. In a cycle where it is low, a zero enters the filter history. A valid flag travels beside the data, so each output result is marked.

Top module: `sysfir_systolic`

## Requirements
- R1: `out_data` equals the sum over k = 0..TAPS-1 of c[k]·x[n-k]. Here x[n] is the newest accepted sample, and tap k's coefficient c[k] is the signed field `coef_i[k*CW +: CW]`.
- R2: A sample presented in cycle c first affects `out_data` in cycle c+TAPS+2. For a unit impulse, c[k] appears on `out_data` in cycle c+TAPS+2+k.
- R3: `out_valid` is high in cycle c+TAPS+2 exactly when `in_valid` was high in cycle c, for every cycle since the last reset.
- R4: In a cycle with `in_valid` low, the filter takes a zero sample and `in_data` is ignored.
- R5: All data are signed two's complement. `out_data` is DW+CW+ceil(log2(TAPS)) bits wide, and it never overflows, even with the most negative samples and coefficients.
- R6: A synchronous active-low reset clears every pipeline register and the valid flags. In the first cycle after reset, `out_valid` and `out_data` are 0, and samples taken before reset no longer contribute.
- R7: After 2·TAPS+2 consecutive cycles with `in_valid` low, `out_data` is 0 and `out_valid` is low.
- R8: Any `TAPS` ≥ 1 builds the same structure. With `TAPS` = 1 the filter is a single scaled sample with a latency of 3 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| coef_i | input | TAPS*CW | Packed signed coefficients, tap k in bits [k*CW +: CW] |
| in_valid | input | 1 | Sample strobe; when low a zero sample is taken |
| in_data | input | DW | Signed input sample |
| out_valid | output | 1 | Marks an output produced by an accepted sample |
| out_data | output | DW+CW+ceil(log2(TAPS)) | Signed filter result |

## Verification
A sample driven in cycle c is captured by the first product register at the edge that ends cycle c. It then passes two more registers for tap 0 and one more register for each later tap. Its result is therefore due in cycle c+TAPS+2, and the flag for it is due in that same cycle.

The bench keeps its own cycle index, set to zero in the first cycle after reset. It records the sample it drives in each cycle, using zero when the strobe is low. Before driving the next input in every cycle, it compares both outputs against a direct-form sum over the history shifted by TAPS+2.

Two instances of order 5 and order 1 run side by side. This shows that the latency formula holds at both ends of the parameter range.

// File: rtl/sysfir_pkg.sv
// Shared helpers for the systolic FIR.
// Assumes signed operands; sizes are elaboration-time constants.
package sysfir_pkg;

    // Width of a partial sum that cannot overflow for the given tap count.
    function automatic int sum_width(input int dw, input int cw, input int taps);
        return dw + cw + $clog2(taps);
    endfunction

endpackage

// File: rtl/fir_delay_pair.sv
// Two-register hop of the sample delay chain between adjacent taps.
// Assumes the pipeline advances every cycle (no stall).
module fir_delay_pair #(
    parameter int DW = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic signed [DW-1:0] x_in,
    output logic signed [DW-1:0] x_out
);

    logic signed [DW-1:0] hop1_q;
    logic signed [DW-1:0] hop2_q;

    // Shift the sample two stages toward the next tap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hop1_q <= '0;
            hop2_q <= '0;
        end else begin
            hop1_q <= x_in;
            hop2_q <= hop1_q;
        end
    end

    assign x_out = hop2_q;

endmodule

// File: rtl/fir_tap.sv
// One systolic tap: a two-stage pipelined multiplier, then a registered
// post-adder that adds the previous tap's partial sum.
// Assumes SW >= DW+CW so the product fits the partial sum unchanged.
module fir_tap #(
    parameter int DW = 16,
    parameter int CW = 16,
    parameter int SW = 34
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic signed [CW-1:0] coef,
    input  logic signed [DW-1:0] x_in,
    input  logic signed [SW-1:0] sum_in,
    output logic signed [SW-1:0] sum_out
);

    localparam int PW = DW + CW;

    logic signed [PW-1:0] prod_s1_q;
    logic signed [PW-1:0] prod_s2_q;
    logic signed [SW-1:0] prod_ext;
    logic signed [SW-1:0] sum_q;

    assign prod_ext = SW'(prod_s2_q);

    // Multiply in stage one, retime in stage two, accumulate in stage three.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prod_s1_q <= '0;
            prod_s2_q <= '0;
            sum_q     <= '0;
        end else begin
            prod_s1_q <= PW'(x_in) * PW'(coef);
            prod_s2_q <= prod_s1_q;
            sum_q     <= prod_ext + sum_in;
        end
    end

    assign sum_out = sum_q;

endmodule

// File: rtl/fir_valid_pipe.sv
// Shift register that carries the sample strobe beside the data path.
// Assumes DEPTH >= 2.
module fir_valid_pipe #(
    parameter int DEPTH = 7
) (
    input  logic clk,
    input  logic rst_n,
    input  logic valid_i,
    output logic valid_o
);

    logic [DEPTH-1:0] flags_q;

    // Move the strobe one stage per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q <= '0;
        end else begin
            flags_q <= {flags_q[DEPTH-2:0], valid_i};
        end
    end

    assign valid_o = flags_q[DEPTH-1];

endmodule

// File: rtl/sysfir_systolic.sv
// Systolic single-rate FIR of order TAPS. Taps are cascaded through a
// sample delay chain (two registers per hop) and a partial-sum chain
// (one register per tap). Result latency is TAPS+2 cycles.
// Assumes coef_i is changed only while rst_n is low.
module sysfir_systolic
    import sysfir_pkg::*;
#(
    parameter int TAPS = 5,
    parameter int DW   = 16,
    parameter int CW   = 16
) (
    input  logic                                     clk,
    input  logic                                     rst_n,
    input  logic [TAPS*CW-1:0]                       coef_i,
    input  logic                                     in_valid,
    input  logic signed [DW-1:0]                     in_data,
    output logic                                     out_valid,
    output logic signed [sum_width(DW, CW, TAPS)-1:0] out_data
);

    localparam int SW      = sum_width(DW, CW, TAPS);
    localparam int LATENCY = TAPS + 2;

    logic signed [DW-1:0] x_chain [0:TAPS-1];
    logic signed [SW-1:0] psum    [0:TAPS];

    // A dropped strobe feeds a zero sample into the history.
    assign x_chain[0] = in_valid ? in_data : '0;
    assign psum[0]    = '0;

    for (genvar k = 0; k < TAPS; k++) begin : g_tap
        fir_tap #(
            .DW (DW),
            .CW (CW),
            .SW (SW)
        ) u_tap (
            .clk     (clk),
            .rst_n   (rst_n),
            .coef    (coef_i[k*CW +: CW]),
            .x_in    (x_chain[k]),
            .sum_in  (psum[k]),
            .sum_out (psum[k+1])
        );

        if (k < TAPS - 1) begin : g_hop
            fir_delay_pair #(
                .DW (DW)
            ) u_hop (
                .clk   (clk),
                .rst_n (rst_n),
                .x_in  (x_chain[k]),
                .x_out (x_chain[k+1])
            );
        end
    end

    fir_valid_pipe #(
        .DEPTH (LATENCY)
    ) u_vpipe (
        .clk     (clk),
        .rst_n   (rst_n),
        .valid_i (in_valid),
        .valid_o (out_valid)
    );

    assign out_data = psum[TAPS];

endmodule

// File: rtl/sysfir_checker.sv
// Temporal checks on the systolic FIR ports, bound into every instance.
module sysfir_checker #(
    parameter int TAPS = 5,
    parameter int SW   = 34
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_valid,
    input logic          out_valid,
    input logic [SW-1:0] out_data
);

    localparam int IDLE_LIM = 2 * TAPS + 2;

    logic rst_q;
    int   idle_cnt;
    int   inflight;

    // Remember the reset level of the previous edge.
    always_ff @(posedge clk) begin
        rst_q <= rst_n;
    end

    // Count consecutive cycles without a sample, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idle_cnt <= IDLE_LIM;
        end else if (in_valid) begin
            idle_cnt <= 0;
        end else if (idle_cnt < IDLE_LIM) begin
            idle_cnt <= idle_cnt + 1;
        end
    end

    // Track samples accepted but not yet reported.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            inflight <= 0;
        end else begin
            inflight <= inflight + (in_valid ? 1 : 0) - (out_valid ? 1 : 0);
        end
    end

    AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        !rst_q |-> (!out_valid && out_data == '0)); // R6

    AST_IDLE_DRAINS: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_cnt == IDLE_LIM) |-> (!out_valid && out_data == '0)); // R7

    AST_VALID_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (idle_cnt <= TAPS + 1)); // R3

    AST_INFLIGHT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (inflight >= 0) && (inflight <= TAPS + 2)); // R3

    AST_INFLIGHT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_cnt >= TAPS + 2) |-> (inflight == 0)); // R3

endmodule

bind sysfir_systolic sysfir_checker #(
    .TAPS (TAPS),
    .SW   (SW)
) u_sysfir_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .out_valid (out_valid),
    .out_data  (out_data)
);

// File: tb/sysfir_systolic_bench.sv
module sysfir_systolic_bench;

    localparam int CLK_PERIOD = 10;
    localparam int DW   = 12;
    localparam int CW   = 10;
    localparam int NA   = 5;
    localparam int NB   = 1;
    localparam int SWA  = DW + CW + $clog2(NA);
    localparam int SWB  = DW + CW + $clog2(NB);
    localparam int HMAX = 1024;

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic                  in_valid = 1'b0;
    logic [DW-1:0]         in_data = '0;
    logic [NA*CW-1:0]      coef_a = '0;
    logic [NB*CW-1:0]      coef_b = '0;
    logic                  vld_a, vld_b;
    logic signed [SWA-1:0] out_a;
    logic signed [SWB-1:0] out_b;

    int     nchk = 0;
    int     nfail = 0;
    int     cur = 0;
    longint hist [HMAX];
    bit     vhist [HMAX];
    int     ca [NA];
    int     cb [NB];

    sysfir_systolic #(.TAPS(NA), .DW(DW), .CW(CW)) u_sysfir_systolic (
        .clk(clk), .rst_n(rst_n), .coef_i(coef_a), .in_valid(in_valid),
        .in_data(in_data), .out_valid(vld_a), .out_data(out_a));

    sysfir_systolic #(.TAPS(NB), .DW(DW), .CW(CW)) u_sysfir_small (
        .clk(clk), .rst_n(rst_n), .coef_i(coef_b), .in_valid(in_valid),
        .in_data(in_data), .out_valid(vld_b), .out_data(out_b));

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic finish_run();
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        nchk++;
        nfail++;
        $display("FAIL R2 watchdog: actual=running expected=finished");
        finish_run();
    end

    task automatic check(string tag, string what, longint act, longint exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s %s cycle %0d: actual=%0d expected=%0d", tag, what, cur, act, exp);
        end
    endtask

    function automatic longint model_a(int c);
        longint s = 0;
        for (int k = 0; k < NA; k++) begin
            int idx = c - (NA + 2) - k;
            if (idx >= 0) s += longint'(ca[k]) * hist[idx];
        end
        return s;
    endfunction

    function automatic longint model_b(int c);
        int idx = c - (NB + 2);
        return (idx >= 0) ? longint'(cb[0]) * hist[idx] : 0;
    endfunction

    function automatic bit vmodel(int c, int taps);
        int idx = c - (taps + 2);
        return (idx >= 0) ? vhist[idx] : 1'b0;
    endfunction

    // At a negedge: check both filters for this cycle, then drive its sample.
    task automatic step(bit v, logic [DW-1:0] d, string tag);
        check(tag, "order5 out_data", longint'(out_a), model_a(cur));
        check(tag, "order5 out_valid R3", longint'(vld_a), longint'(vmodel(cur, NA)));
        check(tag, "R8 order1 out_data", longint'(out_b), model_b(cur));
        check(tag, "R8 order1 out_valid", longint'(vld_b), longint'(vmodel(cur, NB)));
        in_valid = v;
        in_data  = d;
        hist[cur]  = v ? longint'($signed(d)) : 0;
        vhist[cur] = v;
        @(negedge clk);
        cur++;
    endtask

    task automatic set_coefs(int a0, int a1, int a2, int a3, int a4, int b0);
        ca[0] = a0; ca[1] = a1; ca[2] = a2; ca[3] = a3; ca[4] = a4;
        cb[0] = b0;
        for (int k = 0; k < NA; k++) coef_a[k*CW +: CW] = CW'(ca[k]);
        coef_b[CW-1:0] = CW'(cb[0]);
    endtask

    // Hold reset three edges, release, and check the cleared outputs (R6).
    task automatic apply_reset();
        rst_n = 1'b0;
        in_valid = 1'b0;
        in_data = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cur = 0;
        check("R6", "order5 out_valid after reset", longint'(vld_a), 0);
        check("R6", "order5 out_data after reset", longint'(out_a), 0);
        check("R6", "order1 out_data after reset", longint'(out_b), 0);
    endtask

    task automatic t_impulse();
        set_coefs(3, -7, 11, 50, -2, 9);
        apply_reset();
        step(1'b1, 12'd1, "R2");
        for (int i = 0; i < 14; i++) step(1'b1, 12'd0, "R2");
    endtask

    task automatic t_step_input();
        set_coefs(100, 200, -300, 17, 1, -45);
        apply_reset();
        for (int i = 0; i < 16; i++) step(1'b1, 12'd100, "R1");
        for (int i = 0; i < 10; i++) step(1'b1, 12'hF9C, "R1");
    endtask

    task automatic t_extremes();
        set_coefs(-512, -512, -512, -512, -512, -512);
        apply_reset();
        for (int i = 0; i < 12; i++) step(1'b1, 12'h800, "R5");
        set_coefs(511, -512, 511, -512, 511, 511);
        apply_reset();
        for (int i = 0; i < 12; i++) step(1'b1, (i % 2 == 0) ? 12'h7FF : 12'h800, "R5");
    endtask

    task automatic t_gaps();
        set_coefs(5, -4, 3, -2, 1, 6);
        apply_reset();
        for (int i = 0; i < 24; i++) step(i % 3 != 1, (i % 3 == 1) ? 12'hABC : 12'(i * 37), "R4");
    endtask

    task automatic t_drain();
        set_coefs(9, 8, 7, 6, 5, 4);
        apply_reset();
        for (int i = 0; i < 4; i++) step(1'b1, 12'(300 + i), "R7");
        for (int i = 0; i < 2 * NA + 6; i++) step(1'b0, 12'h5A5, "R7");
        check("R7", "order5 out_data drained", longint'(out_a), 0);
        check("R7", "order5 out_valid drained", longint'(vld_a), 0);
    endtask

    task automatic t_reset_midstream();
        set_coefs(21, -13, 8, -5, 3, 2);
        apply_reset();
        for (int i = 0; i < 5; i++) step(1'b1, 12'(700 - 90 * i), "R6");
        apply_reset();
        for (int i = 0; i < 10; i++) step(1'b1, 12'd0, "R6");
    endtask

    task automatic t_random();
        set_coefs(int'($urandom_range(1023)) - 512, int'($urandom_range(1023)) - 512,
                  int'($urandom_range(1023)) - 512, int'($urandom_range(1023)) - 512,
                  int'($urandom_range(1023)) - 512, int'($urandom_range(1023)) - 512);
        apply_reset();
        for (int i = 0; i < 300; i++) step($urandom_range(3) != 0, 12'($urandom), "R1");
    endtask

    initial begin
        @(negedge clk);
        t_impulse();
        t_step_input();
        t_extremes();
        t_gaps();
        t_drain();
        t_reset_midstream();
        t_random();
        finish_run();
    end

endmodule